// File: doc/BRIEF.md
# Ring-Buffer DMA Address Generator

This block produces the memory write addresses for one receive DMA channel that streams bytes into a circular buffer inside a 64K data segment. Incoming bytes pass through a four-slot staging queue. Whenever the queue holds a byte, the block offers a memory write of the oldest byte at the address formed from the segment register and the 16-bit pointer. Each granted write advances the pointer. When the advanced pointer would land on the bound, it instead reloads to the buffer base, which always lies on a 256-byte boundary.

Software programs the channel through a small write port: control, segment, base, bound, pointer and threshold. A transfer counter restarts whenever the threshold is rewritten. A sticky status bit records that the counter has gone past the threshold, and an interrupt line reflects that bit when interrupts are enabled. While all four slots are occupied, the block pushes back on the byte source.

Top module: `dma_ring_addr_gen`

## Requirements
- R1: After reset the pointer, status, interrupt, full flag, memory write strobe, ready and staging word are all zero, and every programmed register reads as zero in its effect.
- R2: in_ready is high exactly when the enable bit (control bit 0) is set and fewer than four bytes are held. A byte is taken only when in_valid and in_ready are both high.
- R3: mem_wr is high whenever at least one byte is held. mem_addr is {segment, pointer} and mem_data is the oldest held byte. A byte leaves on a cycle with mem_wr and mem_gnt both high, and bytes leave in arrival order.
- R4: After a transfer, the pointer becomes pointer+1 modulo 2^16. If that value equals the bound, the pointer becomes {base, 00h} instead.
- R5: A software pointer write in the same cycle as a transfer wins, and the pointer takes the written value.
- R6: A threshold write clears the 17-bit saturating transfer counter, and that clear wins over a same-cycle increment. The status bit sets on a transfer whose incremented count exceeds the threshold, and it stays set until a control write with bit 7 = 1. A set in the same cycle as such a write wins over the clear.
- R7: irq_o equals the status bit ANDed with control bit 1.
- R8: fifo_full is high exactly when four bytes are held, and no byte is accepted then.
- R9: stage_word[7:0] is the oldest held byte and stage_word[15:8] is the next-oldest byte. A slot that holds no byte reads 00h.
- R10: The cfg_sel codes are 0 control, 1 segment, 2 base (low 8 bits), 3 bound, 4 pointer and 5 threshold. Codes 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| in_valid | input | 1 | Received byte valid |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Byte can be accepted |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 24 | {segment, pointer} |
| mem_data | output | 8 | Byte to write |
| mem_gnt | input | 1 | Memory write granted this cycle |
| ptr_o | output | 16 | Current pointer |
| status_o | output | 1 | Sticky threshold-passed status |
| irq_o | output | 1 | Interrupt request |
| fifo_full | output | 1 | All staging slots occupied |
| stage_word | output | 16 | Two oldest held bytes, oldest in low byte |

## Verification
A wrong pointer shows on mem_addr and ptr_o in the cycle after the bad transfer. The error then propagates, because every later address builds on it. A miscounted transfer counter shows up as status_o rising one or more transfers early or late. A staging-queue slip shows on mem_data and stage_word no later than the next write offer. The bench models each of these with its own queue and integers, compares every cycle, and forces frequent wraps, a rollover past FFFFh, full-queue stalls and write collisions.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  localparam int PTR_W  = 16;
  localparam int SEG_W  = 8;
  localparam int BASE_W = PTR_W - 8;
  localparam int CNT_W  = PTR_W + 1;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_SEG   = 3'd1,
    SEL_BASE  = 3'd2,
    SEL_BOUND = 3'd3,
    SEL_PTR   = 3'd4,
    SEL_THR   = 3'd5
  } cfg_sel_e;

  // Advance with wrap: an incremented pointer that hits the bound reloads to the base.
  function automatic logic [PTR_W-1:0] ring_next(input logic [PTR_W-1:0] cur,
                                                 input logic [PTR_W-1:0] bound,
                                                 input logic [BASE_W-1:0] base);
    logic [PTR_W-1:0] inc;
    inc = cur + 1'b1;
    return (inc == bound) ? {base, 8'h00} : inc;
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (&c) ? c : c + 1'b1;
  endfunction
endpackage

// File: rtl/dma_ring_regs.sv
module dma_ring_regs
  import dma_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_sel,
  input  logic [PTR_W-1:0]  cfg_wdata,
  output logic              en_q,
  output logic              irq_en_q,
  output logic [SEG_W-1:0]  seg_q,
  output logic [BASE_W-1:0] base_q,
  output logic [PTR_W-1:0]  bound_q,
  output logic [PTR_W-1:0]  thr_q,
  output logic              ptr_wr,
  output logic              thr_wr,
  output logic              clr_req
);
  logic ctrl_wr;

  assign ctrl_wr = cfg_wr && (cfg_sel == SEL_CTRL);
  assign ptr_wr  = cfg_wr && (cfg_sel == SEL_PTR);
  assign thr_wr  = cfg_wr && (cfg_sel == SEL_THR);
  assign clr_req = ctrl_wr && cfg_wdata[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      irq_en_q <= 1'b0;
      seg_q    <= '0;
      base_q   <= '0;
      bound_q  <= '0;
      thr_q    <= '0;
    end else if (cfg_wr) begin
      case (cfg_sel)
        SEL_CTRL:  begin en_q <= cfg_wdata[0]; irq_en_q <= cfg_wdata[1]; end
        SEL_SEG:   seg_q   <= cfg_wdata[SEG_W-1:0];
        SEL_BASE:  base_q  <= cfg_wdata[BASE_W-1:0];
        SEL_BOUND: bound_q <= cfg_wdata;
        SEL_THR:   thr_q   <= cfg_wdata;
        default: ;
      endcase
    end
  end

  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ctrl_wr, ptr_wr, thr_wr}) <= 1);
endmodule

// File: rtl/dma_stage_fifo.sv
module dma_stage_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic          empty,
  output logic          full,
  output logic          two_held,
  output logic [DW-1:0] head,
  output logic [DW-1:0] second
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DW-1:0]    slot [DEPTH];
  logic [IDX_W-1:0] rd_idx, wr_idx, rd_nxt;
  logic [CNT_W-1:0] count;

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign two_held = (count >= CNT_W'(2));
  assign rd_nxt   = rd_idx + 1'b1;
  assign head     = slot[rd_idx];
  assign second   = slot[rd_nxt];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_idx <= '0;
      wr_idx <= '0;
      count  <= '0;
    end else begin
      if (push) wr_idx <= wr_idx + 1'b1;
      if (pop)  rd_idx <= rd_nxt;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) slot[i] <= '0;
        else if (push && wr_idx == IDX_W'(i)) slot[i] <= din;
      end
    end
  endgenerate

  a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  a_r3_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r8_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/dma_ring_ptr.sv
module dma_ring_ptr
  import dma_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic              ptr_wr,
  input  logic              thr_wr,
  input  logic              clr_req,
  input  logic [PTR_W-1:0]  wdata,
  input  logic [PTR_W-1:0]  bound,
  input  logic [BASE_W-1:0] base,
  input  logic [PTR_W-1:0]  thr,
  output logic [PTR_W-1:0]  ptr_q,
  output logic              status_q
);
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             status_set;

  assign cnt_inc    = sat_inc(cnt_q);
  assign status_set = xfer && (cnt_inc > CNT_W'(thr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      cnt_q    <= '0;
      status_q <= 1'b0;
    end else begin
      if (ptr_wr)    ptr_q <= wdata;
      else if (xfer) ptr_q <= ring_next(ptr_q, bound, base);
      if (thr_wr)    cnt_q <= '0;
      else if (xfer) cnt_q <= cnt_inc;
      if (status_set)   status_q <= 1'b1;
      else if (clr_req) status_q <= 1'b0;
    end
  end

  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !ptr_wr) |=> $stable(ptr_q));
  a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !clr_req) |=> status_q);
  a_r6_status_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(xfer));
endmodule

// File: rtl/dma_ring_addr_gen.sv
module dma_ring_addr_gen
  import dma_ring_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic [2:0]               cfg_sel,
  input  logic [PTR_W-1:0]         cfg_wdata,
  input  logic                     in_valid,
  input  logic [7:0]               in_data,
  output logic                     in_ready,
  output logic                     mem_wr,
  output logic [SEG_W+PTR_W-1:0]   mem_addr,
  output logic [7:0]               mem_data,
  input  logic                     mem_gnt,
  output logic [PTR_W-1:0]         ptr_o,
  output logic                     status_o,
  output logic                     irq_o,
  output logic                     fifo_full,
  output logic [15:0]              stage_word
);
  logic              en_q, irq_en_q, ptr_wr, thr_wr, clr_req;
  logic [SEG_W-1:0]  seg_q;
  logic [BASE_W-1:0] base_q;
  logic [PTR_W-1:0]  bound_q, thr_q;
  logic              push, xfer, q_empty, two_held;
  logic [7:0]        head, second;

  dma_ring_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .en_q(en_q), .irq_en_q(irq_en_q), .seg_q(seg_q), .base_q(base_q), .bound_q(bound_q),
    .thr_q(thr_q), .ptr_wr(ptr_wr), .thr_wr(thr_wr), .clr_req(clr_req)
  );

  assign in_ready = en_q && !fifo_full;
  assign push     = in_valid && in_ready;
  assign mem_wr   = !q_empty;
  assign xfer     = mem_wr && mem_gnt;

  dma_stage_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(in_data), .pop(xfer),
    .empty(q_empty), .full(fifo_full), .two_held(two_held), .head(head), .second(second)
  );

  dma_ring_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .ptr_wr(ptr_wr), .thr_wr(thr_wr),
    .clr_req(clr_req), .wdata(cfg_wdata), .bound(bound_q), .base(base_q), .thr(thr_q),
    .ptr_q(ptr_o), .status_q(status_o)
  );

  assign mem_addr   = {seg_q, ptr_o};
  assign mem_data   = head;
  assign irq_o      = status_o && irq_en_q;
  assign stage_word = {two_held ? second : 8'h00, q_empty ? 8'h00 : head};

  a_r2_no_take_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !in_ready);
  a_r8_full_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !in_ready);
  a_r7_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> status_o);
  a_r3_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_gnt) |=> (mem_wr && $stable(mem_data)));
endmodule

// File: tb/dma_ring_addr_gen_bench.sv
module dma_ring_addr_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic mem_gnt = 1'b0;
  logic in_ready, mem_wr, status_o, irq_o, fifo_full;
  logic [23:0] mem_addr;
  logic [7:0] mem_data;
  logic [15:0] ptr_o, stage_word;

  always #4 clk = ~clk;

  dma_ring_addr_gen u_dma_ring_addr_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_gnt(mem_gnt), .ptr_o(ptr_o),
    .status_o(status_o), .irq_o(irq_o), .fifo_full(fifo_full), .stage_word(stage_word)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // staged inputs
  bit v_wr; int v_sel; int v_wdata; bit v_valid; int v_data; bit v_gnt;

  // reference state
  bit m_en, m_ie, m_st;
  int m_seg, m_base, m_bound, m_thr, m_ptr, m_cnt;
  byte unsigned q[$];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    int sz;
    sz = q.size();
    chk("R2 in_ready", int'(in_ready), int'(m_en && sz < 4));
    chk("R3 mem_wr", int'(mem_wr), int'(sz > 0));
    chk("R3 R10 mem_addr", int'(mem_addr), (m_seg << 16) | m_ptr);
    if (sz > 0) chk("R3 mem_data order", int'(mem_data), int'(q[0]));
    chk("R4 R5 pointer", int'(ptr_o), m_ptr);
    chk("R6 status", int'(status_o), int'(m_st));
    chk("R7 irq", int'(irq_o), int'(m_st && m_ie));
    chk("R8 full", int'(fifo_full), int'(sz == 4));
    chk("R9 stage_word", int'(stage_word),
        ((sz > 1 ? int'(q[1]) : 0) << 8) | (sz > 0 ? int'(q[0]) : 0));
  endtask

  task automatic model_step();
    bit push, pop, set;
    int n, inc;
    push = v_valid && m_en && q.size() < 4;
    pop  = q.size() > 0 && v_gnt;
    inc  = (m_cnt == 131071) ? m_cnt : m_cnt + 1;
    set  = pop && (inc > m_thr);
    if (v_wr && v_sel == 4) m_ptr = v_wdata;
    else if (pop) begin
      n = (m_ptr + 1) & 16'hFFFF;
      m_ptr = (n == m_bound) ? (m_base << 8) : n;
    end
    if (v_wr && v_sel == 5) m_cnt = 0;
    else if (pop) m_cnt = inc;
    if (set) m_st = 1;
    else if (v_wr && v_sel == 0 && v_wdata[7]) m_st = 0;
    if (v_wr) begin
      case (v_sel)
        0: begin m_en = v_wdata[0]; m_ie = v_wdata[1]; end
        1: m_seg = v_wdata & 8'hFF;
        2: m_base = v_wdata & 8'hFF;
        3: m_bound = v_wdata;
        5: m_thr = v_wdata;
        default: ;
      endcase
    end
    if (pop) void'(q.pop_front());
    if (push) q.push_back(byte'(v_data));
  endtask

  task automatic cycle();
    @(negedge clk);
    compare();
    cfg_wr = v_wr; cfg_sel = 3'(v_sel); cfg_wdata = 16'(v_wdata);
    in_valid = v_valid; in_data = 8'(v_data); mem_gnt = v_gnt;
    @(posedge clk);
    model_step();
    v_wr = 0;
  endtask

  task automatic wr(input int sel, input int data);
    v_wr = 1; v_sel = sel; v_wdata = data; v_valid = 0; v_gnt = 0;
    cycle();
  endtask

  task automatic run(input int n, input int pv, input int pg, input int pptr);
    for (int i = 0; i < n; i++) begin
      v_valid = ($urandom % 100) < pv;
      v_data  = $urandom % 256;
      v_gnt   = ($urandom % 100) < pg;
      if (($urandom % 1000) < pptr) begin v_wr = 1; v_sel = 4; v_wdata = $urandom % 65536; end
      else if (($urandom % 300) == 0) begin v_wr = 1; v_sel = 0; v_wdata = 16'h0083; end
      else if (($urandom % 400) == 0) begin v_wr = 1; v_sel = 6 + ($urandom % 2); v_wdata = $urandom % 65536; end
      cycle();
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    chk("R1 pointer", int'(ptr_o), 0);
    chk("R1 status", int'(status_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 full", int'(fifo_full), 0);
    chk("R1 mem_wr", int'(mem_wr), 0);
    chk("R1 in_ready", int'(in_ready), 0);
    chk("R1 stage_word", int'(stage_word), 0);
    rst_n = 1'b1;
    m_en = 0; m_ie = 0; m_st = 0; m_seg = 0; m_base = 0; m_bound = 0;
    m_thr = 0; m_ptr = 0; m_cnt = 0; q.delete();
    v_wr = 0; v_valid = 0; v_gnt = 0; v_data = 0; v_sel = 0; v_wdata = 0;
    // R2: disabled channel ignores bytes
    v_valid = 1; v_data = 8'h5A;
    for (int i = 0; i < 5; i++) cycle();
    // R10: program registers
    wr(1, 16'h003A); wr(2, 16'hFF12); wr(3, 16'h1206); wr(4, 16'h1200);
    wr(5, 5); wr(0, 16'h0003);
    run(1500, 70, 50, 0);
    // R8: fill with no grant
    v_valid = 1; v_gnt = 0;
    for (int i = 0; i < 10; i++) begin v_data = 8'hC0 + i; cycle(); end
    // R4: rollover past FFFF with bound 0
    wr(3, 16'h0000); wr(2, 16'h00A0); wr(4, 16'hFFFD); wr(5, 16'hFFFF);
    run(800, 80, 60, 0);
    // R5: pointer writes colliding with transfers
    wr(3, 16'hA010); wr(5, 3);
    run(1500, 80, 80, 60);
    // R6: clear then fresh threshold
    wr(0, 16'h0081); wr(5, 2);
    run(600, 60, 70, 0);
    // R2: disable again, drain
    wr(0, 16'h0002);
    run(200, 90, 50, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule